// File: doc/BRIEF.md
# Split-Transaction Bulk/Control Buffer

This block is the bulk and control side of a hub transaction translator. The high-speed side delivers start-split and complete-split requests over a single-cycle request port. Each request names a device address, an endpoint number, a direction, a token kind and a payload word. The block answers each request one cycle later. An accepted start-split is parked in one of a small number of slots. Slots waiting for the downstream bus are launched one at a time, oldest first, as full/low-speed transactions over a simple valid/ready request and response pair. The outcome of each transaction (its handshake, and the data for an IN) stays in the slot until a complete-split with the same address, endpoint and direction collects it.

Flow control comes only from the host retrying splits that were refused. There is no PING. The downstream bus is yielded to scheduled traffic: while the `periodic_pending` input is high, no new downstream transaction is offered.

High-side response codes are ACK=0, NAK=1, NYET=2 and STALL=3. Downstream results use ACK=0, NAK=1 and STALL=3, and are passed back unchanged. `hs_req_kind` is 0 for a start-split and 1 for a complete-split. A direction bit of 1 means IN.

Top module: `split_np_buffer`

## Requirements
- R1: After reset, `hs_rsp_valid` and `ds_req_valid` are low, and every slot is free.
- R2: A start-split whose address/endpoint/direction matches no occupied slot, arriving while a slot is free, is answered ACK (code 0) in the cycle after it is sampled, and it occupies one slot.
- R3: A start-split arriving while all NSLOT slots are occupied, with no key match, is answered NAK (code 1), and no slot contents or states change.
- R4: No downstream transaction is offered or accepted while `periodic_pending` is high.
- R5: A downstream request carries the stored address, endpoint, direction, setup flag and (for OUT) payload of its slot. At most one downstream transaction is outstanding: `ds_req_valid` stays low from acceptance until `ds_rsp_valid`.
- R6: A complete-split that matches a slot whose downstream transaction has not finished is answered NYET (code 2), and the slot is kept.
- R7: A complete-split that matches a finished slot returns the stored downstream code unchanged. For an IN that ended in ACK it also returns the data with `hs_rsp_has_data` high; otherwise `hs_rsp_has_data` is low. The slot then becomes free, so a repeated complete-split gets NAK.
- R8: Matching uses address, endpoint and direction together. A complete-split that differs in any one of them from every occupied slot is answered NAK.
- R9: Among slots waiting for the downstream bus, the one accepted earliest is offered first, whatever its slot index.
- R10: A start-split whose address/endpoint/direction matches an occupied slot is answered ACK and takes no further slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periodic_pending | input | 1 | Scheduled traffic owns the downstream bus |
| hs_req_valid | input | 1 | High-side split request present this cycle |
| hs_req_kind | input | 1 | 0 start-split, 1 complete-split |
| hs_req_addr | input | ADDR_W | Device address |
| hs_req_ep | input | EP_W | Endpoint number |
| hs_req_dir | input | 1 | 1 IN, 0 OUT |
| hs_req_setup | input | 1 | Token is a control setup stage |
| hs_req_data | input | DATA_W | OUT/setup payload |
| hs_rsp_valid | output | 1 | Response to the previous cycle's request |
| hs_rsp_code | output | 2 | ACK, NAK, NYET or STALL |
| hs_rsp_has_data | output | 1 | `hs_rsp_data` carries IN data |
| hs_rsp_data | output | DATA_W | Returned IN data |
| ds_req_valid | output | 1 | Downstream transaction offered |
| ds_req_ready | input | 1 | Downstream side takes the offer |
| ds_req_addr | output | ADDR_W | Device address |
| ds_req_ep | output | EP_W | Endpoint number |
| ds_req_dir | output | 1 | 1 IN, 0 OUT |
| ds_req_setup | output | 1 | Setup token |
| ds_req_data | output | DATA_W | OUT/setup payload |
| ds_rsp_valid | input | 1 | Downstream transaction finished |
| ds_rsp_code | input | 2 | Downstream handshake: ACK, NAK or STALL |
| ds_rsp_data | input | DATA_W | IN data |

## Verification
The bench builds the block with NSLOT=3, ADDR_W=7, EP_W=4 and DATA_W=16. Three slots make it possible to fill every slot, refuse a fourth request and recognise a repeat. They also allow a slot with a low index to be freed and reused while older slots with higher indices still wait, which separates age order from index order. A closing sweep runs every slot through ACK, NAK and STALL outcomes in both directions and collects them in reverse order. The expected codes and data are derived from the slot contents the bench itself sent.

// File: rtl/sp_np_pkg.sv
package sp_np_pkg;
  typedef enum logic [1:0] {
    SL_FREE  = 2'd0,
    SL_READY = 2'd1,
    SL_BUSY  = 2'd2,
    SL_DONE  = 2'd3
  } slot_st_e;

  localparam logic [1:0] CODE_ACK   = 2'd0;
  localparam logic [1:0] CODE_NAK   = 2'd1;
  localparam logic [1:0] CODE_NYET  = 2'd2;
  localparam logic [1:0] CODE_STALL = 2'd3;
endpackage

// File: rtl/sp_np_slot.sv
module sp_np_slot
  import sp_np_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              alloc,
  input  logic              issue,
  input  logic              finish,
  input  logic              release_i,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [EP_W-1:0]   req_ep,
  input  logic              req_dir,
  input  logic              req_setup,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        fin_code,
  input  logic [DATA_W-1:0] fin_data,
  output slot_st_e          st,
  output logic [ADDR_W-1:0] addr,
  output logic [EP_W-1:0]   ep,
  output logic              dir,
  output logic              setup,
  output logic [DATA_W-1:0] data,
  output logic [1:0]        code
);
  slot_st_e          st_q, st_d;
  logic              key_en, data_en, code_en;
  logic [DATA_W-1:0] data_d;
  logic [ADDR_W-1:0] addr_q;
  logic [EP_W-1:0]   ep_q;
  logic              dir_q, setup_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        code_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SL_FREE:  if (alloc)     st_d = SL_READY;
      SL_READY: if (issue)     st_d = SL_BUSY;
      SL_BUSY:  if (finish)    st_d = SL_DONE;
      SL_DONE:  if (release_i) st_d = SL_FREE;
      default:                 st_d = SL_FREE;
    endcase
  end

  assign key_en  = alloc;
  assign data_en = alloc | (finish & dir_q);
  assign code_en = finish;
  assign data_d  = alloc ? req_data : fin_data;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= SL_FREE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (key_en) begin
      addr_q  <= req_addr;
      ep_q    <= req_ep;
      dir_q   <= req_dir;
      setup_q <= req_setup;
    end
    if (data_en) data_q <= data_d;
    if (code_en) code_q <= fin_code;
  end

  assign st    = st_q;
  assign addr  = addr_q;
  assign ep    = ep_q;
  assign dir   = dir_q;
  assign setup = setup_q;
  assign data  = data_q;
  assign code  = code_q;

  AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_ni)
    alloc |-> st_q == SL_FREE); // R2
  AST_RELEASE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    release_i |-> st_q == SL_DONE); // R7
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_ni)
    release_i |=> st_q == SL_FREE); // R7
endmodule

// File: rtl/sp_np_age_arb.sv
module sp_np_age_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] ready_vec,
  output logic [N-1:0] grant
);
  // older_q[i][j] set: slot i was accepted before slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        older_d[i][j] = older_q[i][j];
        if (alloc_vec[i])                older_d[i][j] = 1'b0;
        else if (alloc_vec[j] && i != j) older_d[i][j] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) older_q[g] <= '0;
      else         older_q[g] <= older_d[g];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ready_vec[j] && older_q[j][i]) blocked = 1'b1;
      end
      grant[i] = ready_vec[i] && !blocked;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(grant)); // R9
  AST_GRANT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_ni)
    (|ready_vec) |-> (|grant)); // R9
endmodule

// File: rtl/split_np_buffer.sv
module split_np_buffer
  import sp_np_pkg::*;
#(
  parameter int NSLOT  = 2,
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periodic_pending,
  input  logic              hs_req_valid,
  input  logic              hs_req_kind,
  input  logic [ADDR_W-1:0] hs_req_addr,
  input  logic [EP_W-1:0]   hs_req_ep,
  input  logic              hs_req_dir,
  input  logic              hs_req_setup,
  input  logic [DATA_W-1:0] hs_req_data,
  output logic              hs_rsp_valid,
  output logic [1:0]        hs_rsp_code,
  output logic              hs_rsp_has_data,
  output logic [DATA_W-1:0] hs_rsp_data,
  output logic              ds_req_valid,
  input  logic              ds_req_ready,
  output logic [ADDR_W-1:0] ds_req_addr,
  output logic [EP_W-1:0]   ds_req_ep,
  output logic              ds_req_dir,
  output logic              ds_req_setup,
  output logic [DATA_W-1:0] ds_req_data,
  input  logic              ds_rsp_valid,
  input  logic [1:0]        ds_rsp_code,
  input  logic [DATA_W-1:0] ds_rsp_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  slot_st_e          s_st    [NSLOT];
  logic [ADDR_W-1:0] s_addr  [NSLOT];
  logic [EP_W-1:0]   s_ep    [NSLOT];
  logic              s_dir   [NSLOT];
  logic              s_setup [NSLOT];
  logic [DATA_W-1:0] s_data  [NSLOT];
  logic [1:0]        s_code  [NSLOT];

  logic [NSLOT-1:0] free_vec, ready_vec, done_vec, occ, match_vec;
  logic [NSLOT-1:0] first_free, alloc_vec, issue_vec, finish_vec, release_vec, grant;
  logic             start, comp, hit, any_free, hit_done;
  logic [1:0]       hit_code;
  logic             hit_dir;
  logic [DATA_W-1:0] hit_data;

  logic              dn_busy_q, dn_busy_d;
  logic [NSLOT-1:0]  dn_sel_q;
  logic              dn_sel_en, take;

  logic              rsp_valid_d, rsp_has_d;
  logic [1:0]        rsp_code_d;
  logic              rsp_en;

  assign start = hs_req_valid && !hs_req_kind;
  assign comp  = hs_req_valid &&  hs_req_kind;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      free_vec[i]  = s_st[i] == SL_FREE;
      ready_vec[i] = s_st[i] == SL_READY;
      done_vec[i]  = s_st[i] == SL_DONE;
      occ[i]       = !free_vec[i];
      match_vec[i] = occ[i] && s_addr[i] == hs_req_addr &&
                     s_ep[i] == hs_req_ep && s_dir[i] == hs_req_dir;
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    first_free = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!found && free_vec[i]) begin
        first_free[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    hit_code = '0;
    hit_dir  = 1'b0;
    hit_data = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (match_vec[i]) begin
        hit_code = hit_code | s_code[i];
        hit_dir  = hit_dir  | s_dir[i];
        hit_data = hit_data | s_data[i];
      end
    end
  end

  assign hit       = |match_vec;
  assign any_free  = |free_vec;
  assign hit_done  = |(match_vec & done_vec);
  assign alloc_vec = (start && !hit) ? first_free : '0;
  assign release_vec = comp ? (match_vec & done_vec) : '0;

  // high-side response
  always_comb begin
    rsp_valid_d = hs_req_valid;
    rsp_code_d  = CODE_NAK;
    rsp_has_d   = 1'b0;
    if (start) begin
      rsp_code_d = (hit || any_free) ? CODE_ACK : CODE_NAK;
    end else if (comp && hit) begin
      if (hit_done) begin
        rsp_code_d = hit_code;
        rsp_has_d  = hit_dir && (hit_code == CODE_ACK);
      end else begin
        rsp_code_d = CODE_NYET;
      end
    end
  end
  assign rsp_en = comp && hit_done;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_rsp_valid    <= 1'b0;
      hs_rsp_code     <= CODE_ACK;
      hs_rsp_has_data <= 1'b0;
    end else begin
      hs_rsp_valid    <= rsp_valid_d;
      hs_rsp_code     <= rsp_code_d;
      hs_rsp_has_data <= rsp_has_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_en) hs_rsp_data <= hit_data;
  end

  // downstream side
  sp_np_age_arb #(.N(NSLOT)) u_arb (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .alloc_vec (alloc_vec),
    .ready_vec (ready_vec),
    .grant     (grant)
  );

  assign ds_req_valid = !dn_busy_q && !periodic_pending && (|ready_vec);
  assign take         = ds_req_valid && ds_req_ready;
  assign issue_vec    = take ? grant : '0;
  assign finish_vec   = (ds_rsp_valid && dn_busy_q) ? dn_sel_q : '0;

  always_comb begin
    ds_req_addr  = '0;
    ds_req_ep    = '0;
    ds_req_dir   = 1'b0;
    ds_req_setup = 1'b0;
    ds_req_data  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (grant[i]) begin
        ds_req_addr  = ds_req_addr  | s_addr[i];
        ds_req_ep    = ds_req_ep    | s_ep[i];
        ds_req_dir   = ds_req_dir   | s_dir[i];
        ds_req_setup = ds_req_setup | s_setup[i];
        ds_req_data  = ds_req_data  | s_data[i];
      end
    end
  end

  always_comb begin
    dn_busy_d = dn_busy_q;
    if (take)              dn_busy_d = 1'b1;
    else if (ds_rsp_valid) dn_busy_d = 1'b0;
  end
  assign dn_sel_en = take;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_busy_q <= 1'b0;
      dn_sel_q  <= '0;
    end else begin
      dn_busy_q <= dn_busy_d;
      if (dn_sel_en) dn_sel_q <= grant;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    sp_np_slot #(.ADDR_W(ADDR_W), .EP_W(EP_W), .DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_ni    (rst_ni),
      .alloc     (alloc_vec[g]),
      .issue     (issue_vec[g]),
      .finish    (finish_vec[g]),
      .release_i (release_vec[g]),
      .req_addr  (hs_req_addr),
      .req_ep    (hs_req_ep),
      .req_dir   (hs_req_dir),
      .req_setup (hs_req_setup),
      .req_data  (hs_req_data),
      .fin_code  (ds_rsp_code),
      .fin_data  (ds_rsp_data),
      .st        (s_st[g]),
      .addr      (s_addr[g]),
      .ep        (s_ep[g]),
      .dir       (s_dir[g]),
      .setup     (s_setup[g]),
      .data      (s_data[g]),
      .code      (s_code[g])
    );
  end

  AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(dn_busy_q) |-> !$past(periodic_pending)); // R4
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    ds_rsp_valid |-> dn_busy_q); // R5
  AST_NAK_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_ni)
    (hs_rsp_valid && hs_rsp_code == CODE_NAK && $past(start)) |-> occ == $past(occ)); // R3
  AST_NO_OFFER_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(take) |-> !ds_req_valid); // R5
endmodule

// File: tb/split_np_buffer_bench.sv
module split_np_buffer_bench;
  localparam int NSLOT = 3, ADDR_W = 7, EP_W = 4, DATA_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, periodic_pending;
  logic hs_req_valid, hs_req_kind, hs_req_dir, hs_req_setup;
  logic [ADDR_W-1:0] hs_req_addr;
  logic [EP_W-1:0] hs_req_ep;
  logic [DATA_W-1:0] hs_req_data;
  logic hs_rsp_valid, hs_rsp_has_data;
  logic [1:0] hs_rsp_code;
  logic [DATA_W-1:0] hs_rsp_data;
  logic ds_req_valid, ds_req_ready, ds_req_dir, ds_req_setup;
  logic [ADDR_W-1:0] ds_req_addr;
  logic [EP_W-1:0] ds_req_ep;
  logic [DATA_W-1:0] ds_req_data;
  logic ds_rsp_valid;
  logic [1:0] ds_rsp_code;
  logic [DATA_W-1:0] ds_rsp_data;

  split_np_buffer #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .EP_W(EP_W), .DATA_W(DATA_W)) u_split_np_buffer (
    .clk(clk), .rst_n(rst_n), .periodic_pending(periodic_pending),
    .hs_req_valid(hs_req_valid), .hs_req_kind(hs_req_kind), .hs_req_addr(hs_req_addr),
    .hs_req_ep(hs_req_ep), .hs_req_dir(hs_req_dir), .hs_req_setup(hs_req_setup),
    .hs_req_data(hs_req_data), .hs_rsp_valid(hs_rsp_valid), .hs_rsp_code(hs_rsp_code),
    .hs_rsp_has_data(hs_rsp_has_data), .hs_rsp_data(hs_rsp_data),
    .ds_req_valid(ds_req_valid), .ds_req_ready(ds_req_ready), .ds_req_addr(ds_req_addr),
    .ds_req_ep(ds_req_ep), .ds_req_dir(ds_req_dir), .ds_req_setup(ds_req_setup),
    .ds_req_data(ds_req_data), .ds_rsp_valid(ds_rsp_valid), .ds_rsp_code(ds_rsp_code),
    .ds_rsp_data(ds_rsp_data)
  );

  localparam logic [1:0] ACK = 2'd0, NAK = 2'd1, NYET = 2'd2, STALL = 2'd3;

  int total = 0, bad = 0;
  logic [1:0] r_code;
  logic r_has;
  logic [DATA_W-1:0] r_data;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hs_cmd(input logic kind, input logic [ADDR_W-1:0] a, input logic [EP_W-1:0] e,
                        input logic d, input logic s, input logic [DATA_W-1:0] dat);
    @(negedge clk);
    hs_req_valid = 1'b1; hs_req_kind = kind; hs_req_addr = a; hs_req_ep = e;
    hs_req_dir = d; hs_req_setup = s; hs_req_data = dat;
    @(negedge clk);
    hs_req_valid = 1'b0;
    check("R2 response valid", {31'd0, hs_rsp_valid}, 32'd1);
    r_code = hs_rsp_code; r_has = hs_rsp_has_data; r_data = hs_rsp_data;
  endtask

  task automatic serve(input string tag, input logic [ADDR_W-1:0] a, input logic [EP_W-1:0] e,
                       input logic d, input logic s, input logic [DATA_W-1:0] dat,
                       input logic [1:0] rc, input logic [DATA_W-1:0] rd);
    int n = 0;
    while (!ds_req_valid && n < 40) begin @(negedge clk); n++; end
    check({tag, " offered"}, {31'd0, ds_req_valid}, 32'd1);
    check({tag, " addr"}, {25'd0, ds_req_addr}, {25'd0, a});
    check({tag, " ep"}, {28'd0, ds_req_ep}, {28'd0, e});
    check({tag, " dir"}, {31'd0, ds_req_dir}, {31'd0, d});
    check({tag, " setup"}, {31'd0, ds_req_setup}, {31'd0, s});
    if (!d) check({tag, " data"}, {16'd0, ds_req_data}, {16'd0, dat});
    ds_req_ready = 1'b1;
    @(negedge clk);
    ds_req_ready = 1'b0;
    check("R5 no offer while outstanding", {31'd0, ds_req_valid}, 32'd0);
    @(negedge clk);
    check("R5 no offer while outstanding", {31'd0, ds_req_valid}, 32'd0);
    ds_rsp_valid = 1'b1; ds_rsp_code = rc; ds_rsp_data = rd;
    @(negedge clk);
    ds_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; periodic_pending = 1'b1;
    hs_req_valid = 0; hs_req_kind = 0; hs_req_addr = '0; hs_req_ep = '0;
    hs_req_dir = 0; hs_req_setup = 0; hs_req_data = '0;
    ds_req_ready = 0; ds_rsp_valid = 0; ds_rsp_code = '0; ds_rsp_data = '0;
    repeat (3) @(negedge clk);
    check("R1 rsp idle in reset", {31'd0, hs_rsp_valid}, 32'd0);
    check("R1 ds idle in reset", {31'd0, ds_req_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rsp idle after reset", {31'd0, hs_rsp_valid}, 32'd0);
    check("R1 ds idle after reset", {31'd0, ds_req_valid}, 32'd0);

    // fill three slots while scheduled traffic holds the bus
    hs_cmd(0, 7'd5, 4'd1, 0, 0, 16'h1111); check("R2 start A", r_code, ACK);
    hs_cmd(0, 7'd6, 4'd2, 1, 0, 16'h0000); check("R2 start B", r_code, ACK);
    hs_cmd(0, 7'd7, 4'd0, 0, 1, 16'h5E70); check("R2 start C", r_code, ACK);
    repeat (3) @(negedge clk);
    check("R4 held off by periodic", {31'd0, ds_req_valid}, 32'd0);
    hs_cmd(0, 7'd9, 4'd4, 1, 0, 16'h0); check("R3 full NAK", r_code, NAK);
    hs_cmd(0, 7'd5, 4'd1, 0, 0, 16'h1111); check("R10 repeat start ACK", r_code, ACK);
    hs_cmd(1, 7'd5, 4'd1, 0, 0, 16'h0); check("R6 not finished NYET", r_code, NYET);
    hs_cmd(1, 7'd5, 4'd2, 0, 0, 16'h0); check("R8 ep differs NAK", r_code, NAK);
    hs_cmd(1, 7'd5, 4'd1, 1, 0, 16'h0); check("R8 dir differs NAK", r_code, NAK);
    hs_cmd(1, 7'd4, 4'd1, 0, 0, 16'h0); check("R8 addr differs NAK", r_code, NAK);

    periodic_pending = 1'b0;
    serve("R9 first A", 7'd5, 4'd1, 0, 0, 16'h1111, ACK, 16'h0);
    hs_cmd(1, 7'd5, 4'd1, 0, 0, 16'h0);
    check("R7 A code", r_code, ACK);
    check("R7 A no data", {31'd0, r_has}, 32'd0);
    hs_cmd(1, 7'd5, 4'd1, 0, 0, 16'h0); check("R7 A freed", r_code, NAK);
    hs_cmd(0, 7'd9, 4'd4, 1, 0, 16'h0); check("R2 start D into freed slot", r_code, ACK);
    hs_cmd(0, 7'd10, 4'd4, 1, 0, 16'h0); check("R3 R10 full again NAK", r_code, NAK);
    periodic_pending = 1'b1;
    @(negedge clk);
    check("R4 offer withdrawn", {31'd0, ds_req_valid}, 32'd0);
    periodic_pending = 1'b0;
    @(negedge clk);
    check("R4 offer returns", {31'd0, ds_req_valid}, 32'd1);
    serve("R9 second B", 7'd6, 4'd2, 1, 0, 16'h0, ACK, 16'hBEEF);
    serve("R9 third C", 7'd7, 4'd0, 0, 1, 16'h5E70, STALL, 16'h0);
    serve("R9 fourth D", 7'd9, 4'd4, 1, 0, 16'h0, NAK, 16'h0);
    hs_cmd(1, 7'd6, 4'd2, 1, 0, 16'h0);
    check("R7 B code", r_code, ACK);
    check("R7 B has data", {31'd0, r_has}, 32'd1);
    check("R7 B data", {16'd0, r_data}, 32'hBEEF);
    hs_cmd(1, 7'd7, 4'd0, 0, 0, 16'h0); check("R7 C stall", r_code, STALL);
    hs_cmd(1, 7'd9, 4'd4, 1, 0, 16'h0);
    check("R7 D nak passed", r_code, NAK);
    check("R7 D no data", {31'd0, r_has}, 32'd0);
    hs_cmd(1, 7'd9, 4'd4, 1, 0, 16'h0); check("R7 D freed", r_code, NAK);

    // sweep: every slot, every outcome, both directions, collected in reverse
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int k = 0; k < NSLOT; k++) begin
        hs_cmd(0, 7'(20 + k), 4'(k + rnd), 1'((k + rnd) % 2), 0, 16'(16'hA000 + 16 * rnd + k));
        check("R2 sweep start", r_code, ACK);
      end
      for (int k = 0; k < NSLOT; k++) begin
        logic [1:0] c;
        c = ((k + rnd) % 3 == 0) ? ACK : ((k + rnd) % 3 == 1) ? NAK : STALL;
        serve("R9 sweep order", 7'(20 + k), 4'(k + rnd), 1'((k + rnd) % 2), 0,
              16'(16'hA000 + 16 * rnd + k), c, 16'(16'hC000 + 16 * rnd + k));
      end
      for (int k = NSLOT - 1; k >= 0; k--) begin
        logic [1:0] c;
        logic din;
        c = ((k + rnd) % 3 == 0) ? ACK : ((k + rnd) % 3 == 1) ? NAK : STALL;
        din = 1'((k + rnd) % 2);
        hs_cmd(1, 7'(20 + k), 4'(k + rnd), din, 0, 16'h0);
        check("R7 sweep code", r_code, c);
        check("R7 sweep has data", {31'd0, r_has}, {31'd0, din && c == ACK});
        if (din && c == ACK) check("R7 sweep data", {16'd0, r_data}, 32'(16'hC000 + 16 * rnd + k));
        hs_cmd(1, 7'(20 + k), 4'(k + rnd), din, 0, 16'h0);
        check("R7 sweep freed", r_code, NAK);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule